// File: doc/BRIEF.md
# Frequency-Locked Loop Tune Controller

This block is the digital half of a frequency-locked loop. It runs on the fast clock of an on-chip oscillator and measures that clock against a slow reference of 32.768 kHz. Over a window of reference periods it counts fast-clock cycles and compares the count with the count an exactly tuned oscillator would give. The fast clock is meant to run at 150 times the reference, which is 4.9152 MHz.

The signed difference between the target count and the measured count is scaled and added to an integrator. The integrator is the 9-bit tune word that steers the digitally controlled oscillator. A ready flag rises once the measured frequency has stayed within one percent of the target for several windows in a row. When the enable is low the tune word is frozen, so the oscillator runs free at its last setting. The oscillator, the output dividers and the pin muxing sit outside this block.

The design has no data stream. Its inputs and outputs are plain control and status pins, so it has no valid/ready handshake and no back-pressure.

Top module: `fll_tune_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `tune` is 256 (mid-scale) and `clk_ready` is 0.
- R2: `ref_clk` passes through a two-flop synchronizer and is then sampled for rising edges. With the loop enabled, the first rising edge starts a window. A window ends on the 8th rising edge after its start, and that edge also starts the next window. The window count is the number of fast-clock cycles between the start edge and the end edge, and its target is 1200 (150 per reference period).
- R3: At the end of each window, `tune` changes by (1200 − count) shifted right by 2 with sign extension, which rounds toward minus infinity. For example, a count of 1184 adds 4 and a count of 1208 subtracts 2. `tune` changes at no other time.
- R4: `tune` saturates at 0 and at 511 and never wraps around.
- R5: While `fll_en` is low, `tune` holds its value and no window runs. After `fll_en` rises, the next reference rising edge starts a fresh window. The first update then steps from the held value, not from mid-scale.
- R6: `clk_ready` rises at the end of the 4th consecutive window whose error satisfies |1200 − count| ≤ 12. It falls at the end of any window outside that band, and on the clock after `fll_en` goes low.
- R7: In closed loop with an oscillator whose frequency rises as `tune` rises, the loop settles at a tune word where the window count is within 1200 ± 12, and it then asserts `clk_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast oscillator clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | 32.768 kHz reference, asynchronous to clk_fast |
| fll_en | input | 1 | High: loop corrects; low: tune word frozen |
| tune | output | 9 | Oscillator tune word (integrator value) |
| clk_ready | output | 1 | Fast clock is locked within one percent |

## Verification
The same window-end event both steps the integrator and advances the lock streak. The bench therefore provokes the case where the fourth in-band window closes while the tune word is still moving. It drives a fixed oscillator period of 151 reference-relative cycles, so every window carries an error of −8. On that one edge it checks that `tune` has taken exactly its fourth step of −2 and that `clk_ready` rose. It also checks that one window earlier `clk_ready` was still low. A second coincidence is a disable that lands while the flag is set: the bench checks that the flag drops and the tune word stays frozen across the windows that follow.

// File: rtl/fll_pkg.sv
package fll_pkg;
  // Width able to hold a count value up to twice the target.
  function automatic int cnt_width(input int target);
    return $clog2(2 * target + 1);
  endfunction

  // Width of a counter that must reach the value n.
  function automatic int upto_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/fll_ref_edge.sv
module fll_ref_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic rise
);
  logic [SYNC_STAGES:0] chain;

  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= ref_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  // The last stage only serves edge detection.
  assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
endmodule

// File: rtl/fll_window.sv
module fll_window #(
  parameter int REFS  = 8,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rise,
  output logic             done,
  output logic [CNT_W-1:0] count
);
  import fll_pkg::*;
  localparam int EW = upto_width(REFS);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             armed;
  logic [EW-1:0]    edges;
  logic [CNT_W-1:0] cyc;
  logic [CNT_W-1:0] cyc_inc;

  assign cyc_inc = (cyc == CNT_MAX) ? cyc : cyc + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      edges <= '0;
      cyc   <= '0;
      done  <= 1'b0;
      count <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        armed <= 1'b0;
        edges <= '0;
        cyc   <= '0;
      end else if (rise) begin
        if (!armed) begin
          armed <= 1'b1;
          edges <= '0;
          cyc   <= CNT_W'(1);
        end else if (edges == EW'(REFS - 1)) begin
          done  <= 1'b1;
          count <= cyc;
          edges <= '0;
          cyc   <= CNT_W'(1);
        end else begin
          edges <= edges + 1'b1;
          cyc   <= cyc_inc;
        end
      end else if (armed) begin
        cyc <= cyc_inc;
      end
    end
  end
endmodule

// File: rtl/fll_integ.sv
module fll_integ #(
  parameter int TUNE_W = 9,
  parameter int CNT_W  = 12,
  parameter int ERR_W  = 14,
  parameter int TARGET = 1200,
  parameter int SHIFT  = 2,
  parameter int MID    = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    done,
  input  logic [CNT_W-1:0]        count,
  output logic [TUNE_W-1:0]       tune,
  output logic signed [ERR_W-1:0] err
);
  localparam logic signed [ERR_W-1:0] TOP = ERR_W'((1 << TUNE_W) - 1);

  logic signed [ERR_W-1:0] step;
  logic signed [ERR_W-1:0] sum;

  always_comb begin
    err  = $signed(ERR_W'(TARGET)) - $signed(ERR_W'(count));
    step = err >>> SHIFT;
    sum  = $signed(ERR_W'(tune)) + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tune <= TUNE_W'(MID);
    else if (en && done) begin
      if (sum < 0)        tune <= '0;
      else if (sum > TOP) tune <= TOP[TUNE_W-1:0];
      else                tune <= sum[TUNE_W-1:0];
    end
  end
endmodule

// File: rtl/fll_lock.sv
module fll_lock #(
  parameter int ERR_W = 14,
  parameter int TOL   = 12,
  parameter int WINS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    done,
  input  logic signed [ERR_W-1:0] err,
  output logic                    ready
);
  import fll_pkg::*;
  localparam int SW = upto_width(WINS);
  localparam logic signed [ERR_W-1:0] HI = ERR_W'(TOL);
  localparam logic signed [ERR_W-1:0] LO = -HI;

  logic [SW-1:0] streak;
  logic          in_band;

  assign in_band = (err <= HI) && (err >= LO);
  assign ready   = (streak == SW'(WINS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      streak <= '0;
    else if (!en)
      streak <= '0;
    else if (done) begin
      if (!in_band)   streak <= '0;
      else if (!ready) streak <= streak + 1'b1;
    end
  end
endmodule

// File: rtl/fll_tune_ctrl.sv
module fll_tune_ctrl #(
  parameter int TUNE_W    = 9,
  parameter int RATIO     = 150,
  parameter int WIN_REFS  = 8,
  parameter int ERR_SHIFT = 2,
  parameter int LOCK_TOL  = 12,
  parameter int LOCK_WINS = 4,
  parameter int SYNC      = 2
) (
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic              fll_en,
  output logic [TUNE_W-1:0] tune,
  output logic              clk_ready
);
  import fll_pkg::*;
  localparam int TARGET = RATIO * WIN_REFS;
  localparam int CNT_W  = cnt_width(TARGET);
  localparam int ERR_W  = ((CNT_W > TUNE_W) ? CNT_W : TUNE_W) + 2;
  localparam int MID    = 1 << (TUNE_W - 1);

  logic                    ref_rise;
  logic                    win_done;
  logic [CNT_W-1:0]        win_count;
  logic signed [ERR_W-1:0] win_err;

  fll_ref_edge #(.SYNC_STAGES(SYNC)) u_sync (
    .clk(clk_fast), .rst_n(rst_n), .ref_in(ref_clk), .rise(ref_rise)
  );

  fll_window #(.REFS(WIN_REFS), .CNT_W(CNT_W)) u_win (
    .clk(clk_fast), .rst_n(rst_n), .en(fll_en), .rise(ref_rise),
    .done(win_done), .count(win_count)
  );

  fll_integ #(
    .TUNE_W(TUNE_W), .CNT_W(CNT_W), .ERR_W(ERR_W),
    .TARGET(TARGET), .SHIFT(ERR_SHIFT), .MID(MID)
  ) u_integ (
    .clk(clk_fast), .rst_n(rst_n), .en(fll_en), .done(win_done),
    .count(win_count), .tune(tune), .err(win_err)
  );

  fll_lock #(.ERR_W(ERR_W), .TOL(LOCK_TOL), .WINS(LOCK_WINS)) u_lock (
    .clk(clk_fast), .rst_n(rst_n), .en(fll_en), .done(win_done),
    .err(win_err), .ready(clk_ready)
  );
endmodule

// File: rtl/fll_tune_ctrl_chk.sv
module fll_tune_ctrl_chk #(
  parameter int TUNE_W = 9,
  parameter int MID    = 256
) (
  input logic              clk_fast,
  input logic              rst_n,
  input logic              fll_en,
  input logic [TUNE_W-1:0] tune,
  input logic              clk_ready,
  input logic              win_done
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk_fast)
    !rst_n |=> (tune == TUNE_W'(MID)) && !clk_ready);

  // R3
  a_r3_step_only_at_window: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !$stable(tune) |-> $past(win_done && fll_en));

  // R5
  a_r5_hold_when_off: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !fll_en |=> $stable(tune));

  // R6
  a_r6_ready_off_when_disabled: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !fll_en |=> !clk_ready);

  // R6
  a_r6_ready_rises_at_window: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $rose(clk_ready) |-> $past(win_done));
endmodule

bind fll_tune_ctrl fll_tune_ctrl_chk #(.TUNE_W(TUNE_W), .MID(MID)) u_chk (
  .clk_fast(clk_fast), .rst_n(rst_n), .fll_en(fll_en),
  .tune(tune), .clk_ready(clk_ready), .win_done(win_done)
);

// File: tb/sim_fll_tune_ctrl.sv
`timescale 1ns/1ps
module sim_fll_tune_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk;
  logic       fll_en = 1'b1;
  logic [8:0] tune;
  logic       clk_ready;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // oscillator model: period of ref_clk measured in fast cycles
  logic gen_rst = 1'b1;
  bit   closed = 1'b0;
  int   fixed_p = 150;
  int   corner = 256;
  int   ph = 0;
  int   cur_p = 150;
  int   rises = 0;

  always #10 clk = ~clk;

  fll_tune_ctrl u0 (
    .clk_fast(clk), .rst_n(rst_n), .ref_clk(ref_clk), .fll_en(fll_en),
    .tune(tune), .clk_ready(clk_ready)
  );

  function automatic int model_period();
    if (closed) return 150 + (int'(tune) - corner) / 8;
    return fixed_p;
  endfunction

  always @(negedge clk) begin
    if (gen_rst) begin
      ph <= 0;
      ref_clk <= 1'b0;
    end else begin
      if (ph == 0) begin
        cur_p = model_period();
        ref_clk <= 1'b1;
        rises <= rises + 1;
      end else if (ph == cur_p / 2) begin
        ref_clk <= 1'b0;
      end
      ph <= (ph == cur_p - 1) ? 0 : ph + 1;
    end
  end

  task automatic final_report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      final_report();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int p);
    @(negedge clk);
    rst_n = 1'b0;
    gen_rst = 1'b1;
    closed = 1'b0;
    fixed_p = p;
    fll_en = 1'b1;
    repeat (3) @(negedge clk);
    rises = 0;
    rst_n = 1'b1;
    gen_rst = 1'b0;
  endtask

  // wait until the generator has produced n more rising edges, then settle
  task automatic wait_rises(input int n);
    int target;
    target = rises + n;
    while (rises < target) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    gen_rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 tune in reset", tune, 256);
    check("R1 ready in reset", clk_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tune after release", tune, 256);
  endtask

  task automatic t_step();
    do_reset(148);            // count 1184, error +16, step +4
    wait_rises(8);
    check("R2 no update before window end", tune, 256);
    wait_rises(1);
    check("R3 first step", tune, 260);
    wait_rises(8);
    check("R3 second step", tune, 264);
    check("R6 out of band keeps ready low", clk_ready, 0);
  endtask

  task automatic t_ready_count();
    do_reset(151);            // count 1208, error -8, step -2, in band
    wait_rises(32);
    check("R6 ready low after 3 windows", clk_ready, 0);
    check("R3 negative step x3", tune, 250);
    wait_rises(1);
    check("R6 ready after 4th window", clk_ready, 1);
    check("R3 negative step x4", tune, 248);
  endtask

  task automatic t_disable();
    do_reset(151);
    wait_rises(33);
    check("R6 ready before disable", clk_ready, 1);
    fll_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 ready cleared by disable", clk_ready, 0);
    fixed_p = 148;
    wait_rises(16);
    check("R5 tune frozen", tune, 248);
    fll_en = 1'b1;
    wait_rises(8);
    check("R5 no step before new window ends", tune, 248);
    wait_rises(1);
    check("R5 resumes from held value", tune, 252);
  endtask

  task automatic t_ready_drop();
    do_reset(151);
    wait_rises(33);
    check("R6 ready set", clk_ready, 1);
    fixed_p = 148;
    wait_rises(16);
    check("R6 ready dropped on out-of-band window", clk_ready, 0);
  endtask

  task automatic t_sat_hi();
    do_reset(100);            // count 800, error +400, step +100
    wait_rises(9);
    check("R3 big step", tune, 356);
    wait_rises(16);
    check("R4 clamp at 511", tune, 511);
    wait_rises(8);
    check("R4 stays at 511", tune, 511);
  endtask

  task automatic t_sat_lo();
    do_reset(200);            // count 1600, error -400, step -100
    wait_rises(25);
    check("R4 clamp at 0", tune, 0);
    wait_rises(8);
    check("R4 stays at 0", tune, 0);
  endtask

  task automatic t_closed(input int c);
    int cnt;
    do_reset(150);
    corner = c;
    closed = 1'b1;
    wait_rises(200);
    cnt = 8 * model_period();
    check("R7 locked within 1 percent", (cnt >= 1188 && cnt <= 1212) ? 1 : 0, 1);
    check("R7 ready after lock", clk_ready, 1);
  endtask

  initial begin
    ref_clk = 1'b0;
    t_reset();
    t_step();
    t_ready_count();
    t_disable();
    t_ready_drop();
    t_sat_hi();
    t_sat_lo();
    t_closed(300);
    t_closed(205);
    final_report();
  end
endmodule